// File: doc/BRIEF.md
# Serial Receive Port with Ready and Overrun Flags

This block receives 13-bit words over a three-wire serial link (data in, shift clock, active-low select) and hands them to a host through a small bank of 16-bit registers. The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser. A data bit is taken on every detected rising edge of the shift clock, but only while select is low. Bits arrive most significant first.

When the thirteenth bit of a word arrives, the word is copied into the receive register and a ready flag goes high. Reading the receive register clears the flag. If another word completes before the host has read the previous one, the new word replaces it and an overrun flag is latched. The overrun flag stays set until the host writes to the status register. The block has no serial output, and the host sees five 16-bit register slots at word addresses 0 to 4.

Top module: `spi_rx_slave`

## Requirements
- R1: After reset, the receive register (address 0) and the status register (address 1) both read 0.
- R2: While `spi_ss_n` is low, 13 bits sampled on rising `spi_sclk` edges, first bit as bit 12, form a word. The word appears in bits 12:0 of address 0 with bits 15:13 zero, and status bit 7 (ready, value 0x0080) goes to 1.
- R3: A host read strobe at address 0 clears ready and leaves the stored word unchanged.
- R4: If a word completes while ready is 1 and is not being read in that cycle, the new word replaces the stored one, ready stays 1 and status bit 3 (overrun, value 0x0008) goes to 1.
- R5: Overrun stays 1 until a host write strobe at address 1 clears it. That write does not change ready.
- R6: `spi_sclk` edges while `spi_ss_n` is high shift nothing, set no flag and leave the stored word unchanged.
- R7: If `spi_ss_n` rises before 13 bits have arrived, the partial bits are dropped and the next frame starts again at bit 12.
- R8: Addresses 2 to 7 read 0. Host writes to any address other than 1 change no register.
- R9: Several words sent back to back in one low period of `spi_ss_n` are each captured, with the overrun rule of R4 applied between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial shift clock, asynchronous |
| spi_ss_n | input | 1 | Active-low frame select, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| host_addr | input | 3 | Host register word address |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rdata | output | 16 | Read data for `host_addr`, combinational |

## Verification
The assertions assume that each half-period of `spi_sclk` lasts at least two system clocks, so no edge is lost in the synchroniser. They also assume that `spi_mosi` is stable before the rising edge it belongs to and passes through the same number of synchroniser stages as the shift clock. The stimulus holds each shift-clock level for four system clocks, changes data only while the clock is low, and leaves several idle cycles around every change of select. The host strobes are single-cycle pulses driven half a cycle away from the active clock edge.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int REG_W     = 16;
  localparam int READY_BIT = 7;
  localparam int OVR_BIT   = 3;

  typedef enum logic [2:0] {
    A_RXDATA = 3'd0,
    A_STATUS = 3'd1,
    A_RSV2   = 3'd2,
    A_RSV3   = 3'd3,
    A_RSV4   = 3'd4
  } reg_addr_e;

  function automatic logic [REG_W-1:0] pack_status(input logic ready, input logic ovr);
    logic [REG_W-1:0] s;
    s = '0;
    s[READY_BIT] = ready;
    s[OVR_BIT]   = ovr;
    return s;
  endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int WORD_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic sclk_s, ss_s, mosi_s, sclk_q;
  logic sclk_rise, frame_act, bit_take, last_bit;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;

  spi_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
  spi_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_ss (
    .clk(clk), .rst_n(rst_n), .din(ss_n), .dout(ss_s));
  spi_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mosi (
    .clk(clk), .rst_n(rst_n), .din(mosi), .dout(mosi_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign frame_act = ~ss_s;
  assign bit_take  = sclk_rise & frame_act;
  assign last_bit  = (bit_cnt == LAST);
  assign next_word = {shreg[WORD_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!frame_act) begin
      bit_cnt <= '0;
    end else if (bit_take) begin
      shreg   <= next_word;
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      word_done <= bit_take & last_bit;
      if (bit_take & last_bit) word <= next_word;
    end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
  p_done_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(frame_act));
  p_abort_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> bit_cnt == '0);
endmodule

// File: rtl/spi_rx_regs.sv
module spi_rx_regs
  import spi_rx_pkg::*;
#(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        addr,
  input  logic              rd,
  input  logic              wr,
  output logic [REG_W-1:0]  rdata
);
  logic              ready, ovr;
  logic [WORD_W-1:0] rx_q;
  logic              rd_rx, wr_stat, ovr_event;

  function automatic logic [REG_W-1:0] widen(input logic [WORD_W-1:0] w);
    return REG_W'(w);
  endfunction

  assign rd_rx     = rd & (addr == A_RXDATA);
  assign wr_stat   = wr & (addr == A_STATUS);
  assign ovr_event = word_done & ready & ~rd_rx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q  <= '0;
      ready <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (word_done) rx_q <= word;
      if (word_done)  ready <= 1'b1;
      else if (rd_rx) ready <= 1'b0;
      if (ovr_event)    ovr <= 1'b1;
      else if (wr_stat) ovr <= 1'b0;
    end

  always_comb begin
    unique case (addr)
      A_RXDATA: rdata = widen(rx_q);
      A_STATUS: rdata = pack_status(ready, ovr);
      default:  rdata = '0;
    endcase
  end

  p_ready_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> ready);
  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !word_done |=> !ready);
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && ready && !rd_rx |=> ovr);
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !wr_stat |=> ovr);
  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !ovr_event |=> !ovr);
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(rx_q));
endmodule

// File: rtl/spi_rx_slave.sv
module spi_rx_slave
  import spi_rx_pkg::*;
#(
  parameter int WORD_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_ss_n,
  input  logic             spi_mosi,
  input  logic [2:0]       host_addr,
  input  logic             host_rd,
  input  logic             host_wr,
  output logic [REG_W-1:0] host_rdata
);
  logic              word_done;
  logic [WORD_W-1:0] word;

  spi_rx_shift #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) i_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .ss_n(spi_ss_n), .mosi(spi_mosi),
    .word_done(word_done), .word(word));

  spi_rx_regs #(.WORD_W(WORD_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .addr(host_addr), .rd(host_rd), .wr(host_wr), .rdata(host_rdata));

  p_onehot_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_rd, host_wr}));
endmodule

// File: tb/test_spi_rx_slave.sv
module test_spi_rx_slave;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, ss_n = 1, mosi = 0;
  logic [2:0] addr = 0;
  logic rd = 0, wr = 0;
  logic [15:0] rdata;
  int n_chk = 0, n_bad = 0;

  localparam logic [15:0] ST_RDY = 16'h0080;
  localparam logic [15:0] ST_OVR = 16'h0008;
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{13'h0000, 13'h1FFF, 13'h1555,
                                       13'h0AAA, 13'h1000, 13'h0001};

  always #2.5 clk = ~clk;

  spi_rx_slave i_spi_rx_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_ss_n(ss_n), .spi_mosi(mosi),
    .host_addr(addr), .host_rd(rd), .host_wr(wr), .host_rdata(rdata));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [12:0] w, input int nbits);
    for (int i = 12; i > 12 - nbits; i--) begin
      mosi = w[i];
      idle(4); sclk = 1;
      idle(4); sclk = 0;
    end
  endtask

  task automatic frame(input logic [12:0] w);
    ss_n = 0; idle(4);
    shift_bits(w, 13);
    idle(4); ss_n = 1; idle(8);
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata; rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic host_write(input logic [2:0] a);
    @(negedge clk); addr = a; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(4); rst_n = 1; idle(2);
    peek(3'd0, v); chk("R1 rx", v, 16'h0000);
    peek(3'd1, v); chk("R1 status", v, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      frame(VEC[k]);
      peek(3'd1, v);      chk("R2 ready", v, ST_RDY);
      host_read(3'd0, v); chk("R2 data", v, {3'b000, VEC[k]});
      peek(3'd1, v);      chk("R3 cleared", v, 16'h0000);
      peek(3'd0, v);      chk("R3 data kept", v, {3'b000, VEC[k]});
    end

    // R6: clocks while deselected
    mosi = 1;
    for (int i = 0; i < 20; i++) begin idle(4); sclk = 1; idle(4); sclk = 0; end
    idle(8);
    peek(3'd1, v); chk("R6 status", v, 16'h0000);
    peek(3'd0, v); chk("R6 data", v, 16'h0001);

    // R4 overrun and R5 sticky clear
    frame(13'h0123);
    frame(13'h1ABC);
    peek(3'd1, v); chk("R4 status", v, ST_RDY | ST_OVR);
    peek(3'd0, v); chk("R4 data", v, 16'h1ABC);
    host_write(3'd0);
    peek(3'd0, v); chk("R8 write rx", v, 16'h1ABC);
    host_write(3'd2);
    peek(3'd1, v); chk("R5 sticky", v, ST_RDY | ST_OVR);
    host_write(3'd1);
    peek(3'd1, v); chk("R5 cleared", v, ST_RDY);
    host_read(3'd0, v); chk("R3 read", v, 16'h1ABC);
    peek(3'd1, v); chk("R5 after read", v, 16'h0000);

    // R7 aborted partial word
    ss_n = 0; idle(4);
    shift_bits(13'h1FFF, 5);
    idle(4); ss_n = 1; idle(8);
    peek(3'd1, v); chk("R7 no word", v, 16'h0000);
    frame(13'h0A5A);
    peek(3'd1, v);      chk("R7 ready", v, ST_RDY);
    host_read(3'd0, v); chk("R7 data", v, 16'h0A5A);

    // R9 two words in one frame
    ss_n = 0; idle(4);
    shift_bits(13'h1234, 13);
    shift_bits(13'h0F0F, 13);
    idle(4); ss_n = 1; idle(8);
    peek(3'd1, v); chk("R9 status", v, ST_RDY | ST_OVR);
    peek(3'd0, v); chk("R9 data", v, 16'h0F0F);
    host_write(3'd1);
    host_read(3'd0, v);

    // R8 reserved addresses
    for (int a = 2; a < 8; a++) begin
      peek(3'(a), v); chk("R8 reserved", v, 16'h0000);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule